// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block is the device side of a three-wire serial port: an enable line, a serial clock and one data line that both directions share. When the host raises the enable, it shifts in a command byte. Depending on the command, the block then either takes one data byte into a register or streams register contents back to the host. The storage has two banks. The clock bank is a set of byte registers whose values other logic would keep; only the storage is modelled here. The RAM bank holds scratch bytes. A control register sits in the clock bank. Its top bit blocks writes everywhere else.

One special address starts a burst. A burst walks a bank from address 0 upward. A clock-bank burst write is staged and commits only when the whole group is complete. A RAM-bank burst write commits each byte as soon as it completes. The three serial pins are synchronized into a faster system clock, and serial clock edges are found in that domain. The data line is modelled as a separate input, an output and an output enable.

Top module: `tw_reg_slave`

## Requirements
- R1: While the synchronized enable is low, the transfer is aborted and the output enable is low. Dropping the enable in the middle of a read releases the data line.
- R2: The command byte is captured LSB first on rising serial clock edges. Bit 0 set means read and clear means write. Bits 1 to 5 are the address. Bit 6 set selects the RAM bank and clear selects the clock bank. Bit 7 is ignored.
- R3: Read data goes out LSB first. Each bit is driven after a falling edge, and the first bit follows the first falling edge after the command's eighth rising edge. The output enable drops after every rising edge.
- R4: A single write captures eight data bits LSB first on rising edges and commits after the eighth. Any further serial clock cycles in the same transfer change nothing.
- R5: A single read returns the same addressed byte again and again for as long as the enable stays high.
- R6: Address 31 selects a burst. A burst starts at address 0 and steps by one per byte. A burst read wraps to 0 after address 8 in the clock bank and after address 30 in the RAM bank.
- R7: A RAM-bank burst write commits each byte when its eighth bit arrives. Bytes already completed stay written if the transfer is aborted.
- R8: A clock-bank burst write commits addresses 0 to 7 together, only once the eighth byte is received. A burst aborted earlier leaves the bank unchanged.
- R9: Clock-bank address 7 is the control register. Its bit 7 is write protect, and bits 0 to 6 always read 0. While write protect is set, writes to every other location are dropped, but the control register itself stays writable.
- R10: Clock-bank addresses 9 to 30 read 0 and discard writes. Clock address 8 and RAM addresses 0 to 30 store data.
- R11: After reset every location reads 0, write protect is clear and the output enable is low.
- R12: A write whose eight data bits are not all received before the enable drops changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Transfer enable from the host (asynchronous) |
| sck_i | input | 1 | Serial clock from the host (asynchronous) |
| dio_i | input | 1 | Data line as seen at the pad |
| dio_o | output | 1 | Data value driven onto the line |
| dio_oe | output | 1 | High when the block drives the data line |

## Verification
On every cycle the assertions check the timing of the line driver. The driver is released whenever the enable is low and after every rising serial edge. It is only switched on after a falling edge. Register writes happen only on a rising edge, and a single write and a staged burst byte never fire in the same cycle. Whether the stored values and the returned values are right can only be shown by the bench's scenarios. These cover bit order, write-protect gating, locations with no storage, the all-or-nothing clock burst, per-byte RAM commits, burst wrap and aborted transfers.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_DONE = 2'd3
  } tw_phase_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= (s == 0) ? d_i : chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tw_serial.sv
module tw_serial
  import tw_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CLK_REGS  = 9,
  parameter int RAM_DEPTH = 31,
  parameter int CLK_BURST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              din,
  input  logic [7:0]        rd_data,
  output logic              bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en,
  output logic              stg_en,
  output logic [7:0]        wr_data,
  output logic              dout,
  output logic              oe
);
  localparam logic [ADDR_W-1:0] BURST_CODE = '1;
  localparam logic [ADDR_W-1:0] CLK_LAST   = ADDR_W'(CLK_REGS - 1);
  localparam logic [ADDR_W-1:0] RAM_LAST   = ADDR_W'(RAM_DEPTH - 1);
  localparam logic [ADDR_W-1:0] STG_LAST   = ADDR_W'(CLK_BURST - 1);

  tw_phase_e         phase_q, phase_n;
  logic [2:0]        bit_q, bit_n;
  logic [7:0]        sreg_q, sreg_n;
  logic              ram_q, ram_n;
  logic              burst_q, burst_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              dout_q, dout_n;
  logic              oe_q, oe_n;
  logic [7:0]        shifted;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ADDR_W-1:0] rd_last;

  assign shifted  = {din, sreg_q[7:1]};
  assign cmd_addr = sreg_q[ADDR_W+1:2];
  assign rd_last  = ram_q ? RAM_LAST : CLK_LAST;

  always_comb begin
    phase_n = phase_q;
    bit_n   = bit_q;
    sreg_n  = sreg_q;
    ram_n   = ram_q;
    burst_n = burst_q;
    addr_n  = addr_q;
    dout_n  = dout_q;
    oe_n    = oe_q;
    wr_en   = 1'b0;
    stg_en  = 1'b0;
    if (!ce) begin
      phase_n = PH_CMD;
      bit_n   = '0;
      oe_n    = 1'b0;
    end else begin
      unique case (phase_q)
        PH_CMD: if (sck_rise) begin
          sreg_n = shifted;
          bit_n  = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            ram_n   = sreg_q[7];
            burst_n = (cmd_addr == BURST_CODE);
            addr_n  = (cmd_addr == BURST_CODE) ? '0 : cmd_addr;
            phase_n = sreg_q[1] ? PH_RD : PH_WR;
          end
        end
        PH_WR: if (sck_rise) begin
          sreg_n = shifted;
          bit_n  = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            if (!burst_q) begin
              wr_en   = 1'b1;
              phase_n = PH_DONE;
            end else if (ram_q) begin
              wr_en = 1'b1;
              if (addr_q == RAM_LAST) phase_n = PH_DONE;
              else                    addr_n  = addr_q + 1'b1;
            end else begin
              stg_en = 1'b1;
              if (addr_q == STG_LAST) phase_n = PH_DONE;
              else                    addr_n  = addr_q + 1'b1;
            end
          end
        end
        PH_RD: begin
          if (sck_fall) begin
            dout_n = rd_data[bit_q];
            oe_n   = 1'b1;
            bit_n  = bit_q + 3'd1;
            if (bit_q == 3'd7 && burst_q)
              addr_n = (addr_q == rd_last) ? '0 : addr_q + 1'b1;
          end else if (sck_rise) begin
            oe_n = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      bit_q   <= '0;
      sreg_q  <= '0;
      ram_q   <= 1'b0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_n;
      bit_q   <= bit_n;
      sreg_q  <= sreg_n;
      ram_q   <= ram_n;
      burst_q <= burst_n;
      addr_q  <= addr_n;
      dout_q  <= dout_n;
      oe_q    <= oe_n;
    end
  end

  assign bank_o  = ram_q;
  assign addr_o  = addr_q;
  assign wr_data = shifted;
  assign dout    = dout_q;
  assign oe      = oe_q;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int ADDR_W    = 5,
  parameter int CLK_REGS  = 9,
  parameter int RAM_DEPTH = 31,
  parameter int CLK_BURST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              stg_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  localparam int CTRL   = CLK_BURST - 1;
  localparam int CLK_AW = $clog2(CLK_REGS);
  localparam int RAM_AW = $clog2(RAM_DEPTH);

  logic [7:0] clk_mem [CLK_REGS];
  logic [7:0] ram     [RAM_DEPTH];
  logic [7:0] stage   [CTRL];
  logic       wp;
  logic       hit_clk, hit_ram, wr_ctrl, wr_clk_ok, wr_ram_ok, commit;

  assign wp = clk_mem[CTRL][7];

  always_comb begin
    hit_clk   = !bank && (addr < ADDR_W'(CLK_REGS));
    hit_ram   =  bank && (addr < ADDR_W'(RAM_DEPTH));
    wr_ctrl   = wr_en && !bank && (addr == ADDR_W'(CTRL));
    wr_clk_ok = wr_en && hit_clk && !wp;
    wr_ram_ok = wr_en && hit_ram && !wp;
    commit    = stg_en && (addr == ADDR_W'(CTRL));
  end

  genvar i;
  generate
    for (i = 0; i < CLK_REGS; i++) begin : g_clk
      if (i == CTRL) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                clk_mem[i] <= '0;
          else if (wr_ctrl || commit) clk_mem[i] <= {wr_data[7], 7'b0};
        end
      end else if (i < CTRL) begin : g_grp
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            clk_mem[i] <= '0;
            stage[i]   <= '0;
          end else begin
            if (stg_en && addr == ADDR_W'(i)) stage[i] <= wr_data;
            if (commit && !wp)                          clk_mem[i] <= stage[i];
            else if (wr_clk_ok && addr == ADDR_W'(i))   clk_mem[i] <= wr_data;
          end
        end
      end else begin : g_solo
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                               clk_mem[i] <= '0;
          else if (wr_clk_ok && addr == ADDR_W'(i)) clk_mem[i] <= wr_data;
        end
      end
    end
    for (i = 0; i < RAM_DEPTH; i++) begin : g_ram
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               ram[i] <= '0;
        else if (wr_ram_ok && addr == ADDR_W'(i)) ram[i] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (hit_clk)      rd_data = clk_mem[addr[CLK_AW-1:0]];
    else if (hit_ram) rd_data = ram[addr[RAM_AW-1:0]];
  end
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int ADDR_W    = 5,
  parameter int CLK_REGS  = 9,
  parameter int RAM_DEPTH = 31,
  parameter int CLK_BURST = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic sck_i,
  input  logic dio_i,
  output logic dio_o,
  output logic dio_oe
);
  logic              ce_s, sck_s, din_s, sck_d;
  logic              sck_rise, sck_fall;
  logic              bank, wr_en, stg_en;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wr_data, rd_data;

  tw_sync #(.W(3), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({ce_i, sck_i, dio_i}), .q_o({ce_s, sck_s, din_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign sck_rise =  sck_s && !sck_d;
  assign sck_fall = !sck_s &&  sck_d;

  tw_serial #(
    .ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS),
    .RAM_DEPTH(RAM_DEPTH), .CLK_BURST(CLK_BURST)
  ) u_ser (
    .clk(clk), .rst_n(rst_n), .ce(ce_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .din(din_s),
    .rd_data(rd_data), .bank_o(bank), .addr_o(addr),
    .wr_en(wr_en), .stg_en(stg_en), .wr_data(wr_data),
    .dout(dio_o), .oe(dio_oe)
  );

  tw_regfile #(
    .ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS),
    .RAM_DEPTH(RAM_DEPTH), .CLK_BURST(CLK_BURST)
  ) u_rf (
    .clk(clk), .rst_n(rst_n), .bank(bank), .addr(addr),
    .wr_en(wr_en), .stg_en(stg_en), .wr_data(wr_data),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_s,
  input logic sck_rise,
  input logic sck_fall,
  input logic dio_oe,
  input logic wr_en,
  input logic stg_en
);
  assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !dio_oe);

  assert_release_after_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !dio_oe);

  assert_drive_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dio_oe) |-> $past(sck_fall));

  assert_write_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || stg_en) |-> sck_rise);

  assert_one_write_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && stg_en));
endmodule

bind tw_reg_slave tw_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .sck_rise(sck_rise),
  .sck_fall(sck_fall), .dio_oe(dio_oe), .wr_en(wr_en), .stg_en(stg_en)
);

// File: tb/tb_tw_reg_slave.sv
module tb_tw_reg_slave;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_i = 1'b0, sck_i = 1'b0, dio_i = 1'b0;
  logic dio_o, dio_oe;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  tw_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .sck_i(sck_i),
    .dio_i(dio_i), .dio_o(dio_o), .dio_oe(dio_oe)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] cmd(input bit rd, input bit ram, input logic [4:0] a);
    return {1'b1, ram, a, rd};
  endfunction

  task automatic cyc(input logic din, output logic dout, output logic oe_lo, output logic oe_hi);
    dio_i = din;
    wait_clk(HALF);
    dout  = dio_o;
    oe_lo = dio_oe;
    sck_i = 1'b1;
    wait_clk(HALF);
    oe_hi = dio_oe;
    sck_i = 1'b0;
  endtask

  task automatic begin_xfer();
    sck_i = 1'b0;
    ce_i  = 1'b1;
    wait_clk(2*HALF);
  endtask

  task automatic end_xfer(input string tag);
    wait_clk(2*HALF);
    ce_i = 1'b0;
    wait_clk(8);
    check(tag, {7'b0, dio_oe}, 8'h00);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic d, l, h;
    for (int i = 0; i < 8; i++) cyc(b[i], d, l, h);
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic ok);
    logic d, l, h;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, d, l, h);
      b[i] = d;
      if (!(l === 1'b1 && h === 1'b0)) ok = 1'b0;
    end
  endtask

  task automatic write1(input bit ram, input logic [4:0] a, input logic [7:0] v);
    begin_xfer();
    send_byte(cmd(1'b0, ram, a));
    send_byte(v);
    end_xfer("R1 release after write");
  endtask

  task automatic read1(input string tag, input bit ram, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] b;
    logic ok;
    begin_xfer();
    send_byte(cmd(1'b1, ram, a));
    recv_byte(b, ok);
    check(tag, b, exp);
    check("R3 drive after fall, release after rise", {7'b0, ok}, 8'h01);
    end_xfer("R1 release after read");
  endtask

  task automatic t_reset();
    check("R11 output enable low after reset", {7'b0, dio_oe}, 8'h00);
    read1("R11 RAM reads zero after reset", 1'b1, 5'd0, 8'h00);
    read1("R11 control clear after reset", 1'b0, 5'd7, 8'h00);
  endtask

  task automatic t_single();
    write1(1'b1, 5'd5, 8'hA5);
    read1("R4 RAM single write/read", 1'b1, 5'd5, 8'hA5);
    write1(1'b0, 5'd2, 8'h3C);
    read1("R2 clock bank select", 1'b0, 5'd2, 8'h3C);
    read1("R2 address decode neighbour untouched", 1'b1, 5'd4, 8'h00);
    read1("R2 bank bit separates banks", 1'b0, 5'd5, 8'h00);
  endtask

  task automatic t_extra_write();
    begin_xfer();
    send_byte(cmd(1'b0, 1'b1, 5'd6));
    send_byte(8'h5A);
    send_byte(8'hFF);
    end_xfer("R1 release");
    read1("R4 extra cycles after write ignored", 1'b1, 5'd6, 8'h5A);
  endtask

  task automatic t_repeat();
    logic [7:0] b;
    logic ok;
    begin_xfer();
    send_byte(cmd(1'b1, 1'b1, 5'd5));
    recv_byte(b, ok);
    check("R5 first byte", b, 8'hA5);
    recv_byte(b, ok);
    check("R5 repeated byte", b, 8'hA5);
    end_xfer("R1 release");
  endtask

  task automatic t_wp();
    write1(1'b0, 5'd7, 8'hFF);
    read1("R9 control low bits read zero", 1'b0, 5'd7, 8'h80);
    write1(1'b1, 5'd5, 8'h11);
    read1("R9 RAM write blocked", 1'b1, 5'd5, 8'hA5);
    write1(1'b0, 5'd2, 8'h77);
    read1("R9 clock write blocked", 1'b0, 5'd2, 8'h3C);
    write1(1'b0, 5'd7, 8'h00);
    read1("R9 control writable while protected", 1'b0, 5'd7, 8'h00);
    write1(1'b1, 5'd5, 8'h11);
    read1("R9 RAM write after unprotect", 1'b1, 5'd5, 8'h11);
  endtask

  task automatic t_nostore();
    write1(1'b0, 5'd12, 8'h99);
    read1("R10 clock address 12 has no storage", 1'b0, 5'd12, 8'h00);
    write1(1'b0, 5'd8, 8'h42);
    read1("R10 clock address 8 stores", 1'b0, 5'd8, 8'h42);
    write1(1'b1, 5'd30, 8'h6D);
    read1("R10 RAM address 30 stores", 1'b1, 5'd30, 8'h6D);
  endtask

  task automatic t_ram_burst();
    logic d, l, h;
    begin_xfer();
    send_byte(cmd(1'b0, 1'b1, 5'd31));
    send_byte(8'h10);
    send_byte(8'h20);
    send_byte(8'h30);
    for (int i = 0; i < 4; i++) cyc(1'b1, d, l, h);
    end_xfer("R1 release");
    read1("R7 burst byte 0", 1'b1, 5'd0, 8'h10);
    read1("R7 burst byte 1", 1'b1, 5'd1, 8'h20);
    read1("R7 burst byte 2", 1'b1, 5'd2, 8'h30);
    read1("R7 partial byte dropped", 1'b1, 5'd3, 8'h00);
  endtask

  task automatic t_clk_burst();
    begin_xfer();
    send_byte(cmd(1'b0, 1'b0, 5'd31));
    for (int i = 0; i < 5; i++) send_byte(8'hE0 + 8'(i));
    end_xfer("R1 release");
    read1("R8 aborted burst leaves reg 0", 1'b0, 5'd0, 8'h00);
    read1("R8 aborted burst leaves reg 2", 1'b0, 5'd2, 8'h3C);
    begin_xfer();
    send_byte(cmd(1'b0, 1'b0, 5'd31));
    for (int i = 0; i < 7; i++) send_byte(8'hC0 + 8'(i));
    send_byte(8'h00);
    end_xfer("R1 release");
    read1("R8 full burst reg 0", 1'b0, 5'd0, 8'hC0);
    read1("R8 full burst reg 2", 1'b0, 5'd2, 8'hC2);
    read1("R8 full burst reg 6", 1'b0, 5'd6, 8'hC6);
    read1("R8 reg 8 outside burst group", 1'b0, 5'd8, 8'h42);
  endtask

  task automatic t_burst_read();
    logic [7:0] b;
    logic ok;
    begin_xfer();
    send_byte(cmd(1'b1, 1'b0, 5'd31));
    for (int i = 0; i < 10; i++) begin
      recv_byte(b, ok);
      if (i == 0) check("R6 clock burst starts at 0", b, 8'hC0);
      if (i == 3) check("R6 clock burst steps", b, 8'hC3);
      if (i == 7) check("R6 clock burst control", b, 8'h00);
      if (i == 8) check("R6 clock burst addr 8", b, 8'h42);
      if (i == 9) check("R6 clock burst wraps", b, 8'hC0);
    end
    end_xfer("R1 release");
    begin_xfer();
    send_byte(cmd(1'b1, 1'b1, 5'd31));
    for (int i = 0; i < 32; i++) begin
      recv_byte(b, ok);
      if (i == 1)  check("R6 RAM burst addr 1", b, 8'h20);
      if (i == 30) check("R6 RAM burst addr 30", b, 8'h6D);
      if (i == 31) check("R6 RAM burst wraps", b, 8'h10);
    end
    end_xfer("R1 release");
  endtask

  task automatic t_abort();
    logic d, l, h;
    begin_xfer();
    send_byte(cmd(1'b0, 1'b1, 5'd7));
    for (int i = 0; i < 4; i++) cyc(1'b1, d, l, h);
    end_xfer("R1 release");
    read1("R12 aborted write no effect", 1'b1, 5'd7, 8'h00);
    begin_xfer();
    send_byte(cmd(1'b1, 1'b1, 5'd0));
    for (int i = 0; i < 3; i++) cyc(1'b0, d, l, h);
    wait_clk(HALF);
    check("R3 driving mid read", {7'b0, dio_oe}, 8'h01);
    ce_i = 1'b0;
    wait_clk(6);
    check("R1 abort mid read releases line", {7'b0, dio_oe}, 8'h00);
    wait_clk(HALF);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_single();
    t_extra_write();
    t_repeat();
    t_wp();
    t_nostore();
    t_ram_burst();
    t_clk_burst();
    t_burst_read();
    t_abort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule